// File: doc/BRIEF.md
# CPU Packet Buffer Handshake Controller

This block owns the two single-packet buffers that sit between a packet router and a processor. One buffer (the receive buffer) is filled by the router and handed to the CPU. The other buffer (the transmit buffer) is filled by the CPU and handed back to the router for draining. The buffer RAM lives outside the block. Only the ownership state and the status encoding are built here.

The CPU drives two control words through settings registers and reads one status word. Ownership moves through a four-phase level handshake. First the block raises a status flag. The CPU then raises its control bit, and the block drops the flag. Finally the CPU lowers its control bit, and only after that may the flag rise again. Line counts travel in the upper 16 bits of the control and status words. On the stream side, a fill port reports completed receive packets, and a drain port presents committed transmit packets until the drain logic acknowledges them.

Top module: `pktbuf_handshake`

## Requirements
- R1: After reset, `status_o` reads 32'h0000_0002, `fill_ready_o` is 1 and `drain_valid_o` is 0. The router owns the receive buffer, and the transmit buffer is offered to the CPU.
- R2: While `fill_ready_o` is 1, a cycle with `fill_done_i` high makes `status_o[0]` read 1 from the next cycle. In that cycle `status_o[31:16]` equals the `fill_lines_i` value sampled with the done pulse, and `fill_ready_o` is 0.
- R3: `rx_ctrl_i[0]` is the release bit. When it is seen high while `status_o[0]` is 1, `status_o[0]` reads 0 from the next cycle. A `fill_done_i` pulse arriving while the router does not own the receive buffer has no effect on `status_o`.
- R4: After a release, `fill_ready_o` stays 0 while `rx_ctrl_i[0]` remains 1. It rises one cycle after `rx_ctrl_i[0]` is seen at 0. `status_o[0]` stays 0 until a new `fill_done_i` is accepted.
- R5: `status_o[1]` is 1 while the transmit buffer is free for the CPU. A 0-to-1 transition of `tx_ctrl_i[0]` while it is 1 makes the next cycle read `status_o[1]`=0 and `drain_valid_o`=1, with `drain_lines_o` equal to the `tx_ctrl_i[31:16]` sampled on that edge.
- R6: While `drain_valid_o` is 1, `drain_lines_o` holds its value. Changes on `tx_ctrl_i[31:16]` have no effect on it.
- R7: `drain_done_i` high while `drain_valid_o` is 1 clears `drain_valid_o` on the next cycle. `status_o[1]` rises again only one cycle after `tx_ctrl_i[0]` is seen at 0, following that completion.
- R8: A commit with a line count of 0 is accepted. It presents `drain_valid_o`=1 with `drain_lines_o`=0 and needs `drain_done_i` like any other packet.
- R9: `status_o[15:2]` always reads 0, and `status_o[31:16]` reads 0 whenever `status_o[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_ctrl_i | input | 32 | Receive control word; bit 0 releases the receive buffer |
| tx_ctrl_i | input | 32 | Transmit control word; bit 0 commits, bits 31:16 give the line count |
| status_o | output | 32 | Bit 0 receive ready, bit 1 transmit free, bits 31:16 receive length |
| fill_ready_o | output | 1 | Router may write the receive buffer |
| fill_done_i | input | 1 | Router finished a receive packet |
| fill_lines_i | input | 16 | Length in lines of the finished receive packet |
| drain_valid_o | output | 1 | A committed transmit packet awaits draining |
| drain_lines_o | output | 16 | Line count of the committed transmit packet |
| drain_done_i | input | 1 | Drain logic finished the transmit packet |

## Verification
The receive release and the transmit commit are independent, so both can land in the same clock. Likewise, a fill completion can coincide with a drain completion. The bench brings both buffers into the CPU-facing state with the control bits low, then raises the release bit and the commit bit on the same edge. It expects both status flags to fall together, with the committed count on the drain port. Random toggling of all four handshake inputs also produces such collisions, and each one is judged cycle by cycle against a reference model built from the requirements.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;

   localparam int CTRL_W   = 32;
   localparam int CNT_W    = 16;
   localparam int CNT_LSB  = 16;
   localparam int BIT_RXRD = 0;
   localparam int BIT_TXFR = 1;

   typedef enum logic [1:0] {
      RX_ROUTER = 2'd0,
      RX_CPU    = 2'd1,
      RX_HOLD   = 2'd2
   } rx_own_e;

   typedef enum logic [1:0] {
      TX_CPU    = 2'd0,
      TX_DRAIN  = 2'd1,
      TX_HOLD   = 2'd2
   } tx_own_e;

endpackage

// File: rtl/pktbuf_rx_owner.sv
module pktbuf_rx_owner
   import pktbuf_pkg::*;
#(
   parameter int LEN_W = 16
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             rel_i,
   input  logic             fill_done_i,
   input  logic [LEN_W-1:0] fill_lines_i,
   output logic             fill_ready_o,
   output logic             cpu_own_o,
   output logic [LEN_W-1:0] len_o
);

   rx_own_e          state_q;
   logic [LEN_W-1:0] len_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= RX_ROUTER;
         len_q   <= '0;
      end else begin
         unique case (state_q)
            RX_ROUTER: if (fill_done_i) begin
               state_q <= RX_CPU;
               len_q   <= fill_lines_i;
            end
            RX_CPU:    if (rel_i)  state_q <= RX_HOLD;
            RX_HOLD:   if (!rel_i) state_q <= RX_ROUTER;
            default:   state_q <= RX_ROUTER;
         endcase
      end
   end

   assign fill_ready_o = (state_q == RX_ROUTER);
   assign cpu_own_o    = (state_q == RX_CPU);
   assign len_o        = len_q;

   // R2
   fill_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (fill_ready_o && fill_done_i) |=> (cpu_own_o && len_o == $past(fill_lines_i)));

   // R3
   release_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (cpu_own_o && rel_i) |=> !cpu_own_o);

   // R4
   no_early_rearm_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(fill_ready_o) |-> $past(!rel_i));

endmodule

// File: rtl/pktbuf_tx_owner.sv
module pktbuf_tx_owner
   import pktbuf_pkg::*;
#(
   parameter int LEN_W = 16
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             commit_i,
   input  logic [LEN_W-1:0] count_i,
   input  logic             drain_done_i,
   output logic             offer_o,
   output logic             valid_o,
   output logic [LEN_W-1:0] lines_o
);

   tx_own_e          state_q;
   logic [LEN_W-1:0] cnt_q;
   logic             commit_q;
   logic             commit_rise;

   assign commit_rise = commit_i && !commit_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= TX_CPU;
         cnt_q    <= '0;
         commit_q <= 1'b0;
      end else begin
         commit_q <= commit_i;
         unique case (state_q)
            TX_CPU:   if (commit_rise) begin
               state_q <= TX_DRAIN;
               cnt_q   <= count_i;
            end
            TX_DRAIN: if (drain_done_i) state_q <= TX_HOLD;
            TX_HOLD:  if (!commit_i)    state_q <= TX_CPU;
            default:  state_q <= TX_CPU;
         endcase
      end
   end

   assign offer_o = (state_q == TX_CPU);
   assign valid_o = (state_q == TX_DRAIN);
   assign lines_o = cnt_q;

   // R5
   commit_take_chk: assert property (@(posedge clk) disable iff (rst)
      (offer_o && $rose(commit_i)) |=> (valid_o && !offer_o && lines_o == $past(count_i)));

   // R6
   count_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_o && $past(valid_o)) |-> $stable(lines_o));

   // R7
   reoffer_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(offer_o) |-> $past(!commit_i));

   // R7
   done_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_o && drain_done_i) |=> !valid_o);

endmodule

// File: rtl/pktbuf_status_pack.sv
module pktbuf_status_pack
   import pktbuf_pkg::*;
#(
   parameter int LEN_W         = 16,
   parameter bit MASK_IDLE_LEN = 1'b1
)(
   input  logic              rx_ready_i,
   input  logic              tx_free_i,
   input  logic [LEN_W-1:0]  rx_len_i,
   output logic [CTRL_W-1:0] status_o
);

   localparam int PAD_W = CNT_W - LEN_W;

   logic [CNT_W-1:0] len_field;

   generate
      if (MASK_IDLE_LEN) begin : g_masked
         assign len_field = rx_ready_i ? CNT_W'(rx_len_i) : '0;
      end else begin : g_raw
         assign len_field = CNT_W'(rx_len_i);
      end
   endgenerate

   always_comb begin
      status_o                       = '0;
      status_o[BIT_RXRD]             = rx_ready_i;
      status_o[BIT_TXFR]             = tx_free_i;
      status_o[CTRL_W-1:CNT_LSB]     = len_field;
   end

   initial begin
      if (PAD_W < 0) $error("LEN_W exceeds status count field");
   end

endmodule

// File: rtl/pktbuf_handshake.sv
module pktbuf_handshake
   import pktbuf_pkg::*;
#(
   parameter int LINE_W    = 16,
   parameter int BUF_LINES = 512
)(
   input  logic        clk,
   input  logic        rst,
   input  logic [31:0] rx_ctrl_i,
   input  logic [31:0] tx_ctrl_i,
   output logic [31:0] status_o,
   output logic        fill_ready_o,
   input  logic        fill_done_i,
   input  logic [15:0] fill_lines_i,
   output logic        drain_valid_o,
   output logic [15:0] drain_lines_o,
   input  logic        drain_done_i
);

   localparam int MIN_W = $clog2(BUF_LINES + 1);

   generate
      if (LINE_W > CNT_W) begin : g_bad_w
         $error("LINE_W wider than the 16-bit count field");
      end
      if (MIN_W > LINE_W) begin : g_bad_depth
         $error("LINE_W cannot express BUF_LINES");
      end
   endgenerate

   logic              rx_cpu;
   logic              tx_offer;
   logic [LINE_W-1:0] rx_len;
   logic [LINE_W-1:0] tx_lines;

   pktbuf_rx_owner #(.LEN_W(LINE_W)) rx_i (
      .clk          (clk),
      .rst          (rst),
      .rel_i        (rx_ctrl_i[0]),
      .fill_done_i  (fill_done_i),
      .fill_lines_i (fill_lines_i[LINE_W-1:0]),
      .fill_ready_o (fill_ready_o),
      .cpu_own_o    (rx_cpu),
      .len_o        (rx_len)
   );

   pktbuf_tx_owner #(.LEN_W(LINE_W)) tx_i (
      .clk          (clk),
      .rst          (rst),
      .commit_i     (tx_ctrl_i[0]),
      .count_i      (tx_ctrl_i[CNT_LSB +: LINE_W]),
      .drain_done_i (drain_done_i),
      .offer_o      (tx_offer),
      .valid_o      (drain_valid_o),
      .lines_o      (tx_lines)
   );

   pktbuf_status_pack #(.LEN_W(LINE_W), .MASK_IDLE_LEN(1'b1)) st_i (
      .rx_ready_i (rx_cpu),
      .tx_free_i  (tx_offer),
      .rx_len_i   (rx_len),
      .status_o   (status_o)
   );

   assign drain_lines_o = CNT_W'(tx_lines);

   // R9
   idle_len_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !status_o[0] |-> (status_o[31:16] == 16'h0));

endmodule

// File: tb/pktbuf_handshake_tb.sv
module pktbuf_handshake_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] rx_ctrl = '0;
   logic [31:0] tx_ctrl = '0;
   logic [31:0] status;
   logic        fill_ready;
   logic        fill_done = 1'b0;
   logic [15:0] fill_lines = '0;
   logic        drain_valid;
   logic [15:0] drain_lines;
   logic        drain_done = 1'b0;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   always #10 clk = ~clk;

   pktbuf_handshake dut_i (
      .clk           (clk),
      .rst           (rst),
      .rx_ctrl_i     (rx_ctrl),
      .tx_ctrl_i     (tx_ctrl),
      .status_o      (status),
      .fill_ready_o  (fill_ready),
      .fill_done_i   (fill_done),
      .fill_lines_i  (fill_lines),
      .drain_valid_o (drain_valid),
      .drain_lines_o (drain_lines),
      .drain_done_i  (drain_done)
   );

   // reference model: rx 0 router,1 cpu,2 hold ; tx 0 cpu,1 drain,2 hold
   int          m_rx = 0;
   int          m_tx = 0;
   logic [15:0] m_len = '0;
   logic [15:0] m_cnt = '0;
   logic        m_cq = 1'b0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst) begin
         m_rx <= 0; m_tx <= 0; m_len <= '0; m_cnt <= '0; m_cq <= 1'b0;
      end else begin
         m_cq <= tx_ctrl[0];
         case (m_rx)
            0: if (fill_done) begin m_rx <= 1; m_len <= fill_lines; end
            1: if (rx_ctrl[0]) m_rx <= 2;
            default: if (!rx_ctrl[0]) m_rx <= 0;
         endcase
         case (m_tx)
            0: if (tx_ctrl[0] && !m_cq) begin m_tx <= 1; m_cnt <= tx_ctrl[31:16]; end
            1: if (drain_done) m_tx <= 2;
            default: if (!tx_ctrl[0]) m_tx <= 0;
         endcase
      end
   end

   function automatic logic [31:0] exp_status();
      return {(m_rx == 1) ? m_len : 16'h0, 14'h0, m_tx == 0, m_rx == 1};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s cycle %0d actual %h expected %h", req, cyc, act, expv);
      end
   endtask

   task automatic check_all();
      logic [31:0] e;
      e = exp_status();
      chk("R2/R3 rx flag", 32'(status[0]), 32'(e[0]));
      chk("R5/R7 tx flag", 32'(status[1]), 32'(e[1]));
      chk("R2/R9 length field", 32'(status[31:16]), 32'(e[31:16]));
      chk("R9 reserved bits", 32'(status[15:2]), 32'h0);
      chk("R4 fill_ready", 32'(fill_ready), 32'(m_rx == 0));
      chk("R5/R7 drain_valid", 32'(drain_valid), 32'(m_tx == 1));
      if (m_tx == 1) chk("R6/R8 drain_lines", 32'(drain_lines), 32'(m_cnt));
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // watchdog
   initial begin
      #(20 * 150000);
      checks++; errors++;
      $display("FAIL watchdog cycle %0d actual hung expected done", cyc);
      finish_run();
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1 status", status, 32'h0000_0002);
      chk("R1 fill_ready", 32'(fill_ready), 32'h1);
      chk("R1 drain_valid", 32'(drain_valid), 32'h0);

      // R8 zero-length commit, directed
      tx_ctrl = 32'h0000_0001;
      @(negedge clk);
      check_all();
      chk("R8 zero-length valid", 32'(drain_valid), 32'h1);
      chk("R8 zero-length count", 32'(drain_lines), 32'h0);
      tx_ctrl = 32'hABCD_0001;          // R6 upper bits change, ignored
      repeat (3) begin @(negedge clk); check_all(); end
      chk("R8 still waiting for done", 32'(drain_valid), 32'h1);
      drain_done = 1'b1;
      @(negedge clk); check_all();
      drain_done = 1'b0;
      @(negedge clk); check_all();
      chk("R7 held until commit low", 32'(status[1]), 32'h0);
      tx_ctrl = 32'h0;
      @(negedge clk); check_all();
      chk("R7 re-offered", 32'(status[1]), 32'h1);

      // R3 fill then release, fill_done during hold ignored
      fill_done = 1'b1; fill_lines = 16'd512;
      @(negedge clk); check_all();
      chk("R2 length 512", 32'(status[31:16]), 32'd512);
      fill_done = 1'b0;
      rx_ctrl = 32'h1;
      @(negedge clk); check_all();
      fill_done = 1'b1; fill_lines = 16'd7;
      repeat (2) begin @(negedge clk); check_all(); end
      chk("R3 ignored fill keeps flag low", 32'(status[0]), 32'h0);
      fill_done = 1'b0; rx_ctrl = 32'h0;
      @(negedge clk); check_all();
      chk("R4 fill_ready back", 32'(fill_ready), 32'h1);

      // same-cycle release and commit
      fill_done = 1'b1; fill_lines = 16'd33;
      @(negedge clk); check_all();
      fill_done = 1'b0;
      rx_ctrl = 32'h1; tx_ctrl = 32'h0040_0001;
      @(negedge clk); check_all();
      chk("R3/R5 both flags drop", 32'(status[1:0]), 32'h0);
      chk("R5 collided count", 32'(drain_lines), 32'h40);
      rx_ctrl = 32'h0; drain_done = 1'b1;
      @(negedge clk); check_all();
      drain_done = 1'b0; tx_ctrl = 32'h0;
      @(negedge clk); check_all();

      // constrained random phase
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(3) == 0) rx_ctrl[0] = ~rx_ctrl[0];
         if ($urandom_range(3) == 0) tx_ctrl[0] = ~tx_ctrl[0];
         if ($urandom_range(1) == 0)
            tx_ctrl[31:16] = ($urandom_range(7) == 0) ? 16'h0 : 16'($urandom);
         fill_done  = ($urandom_range(2) == 0);
         fill_lines = 16'($urandom_range(512));
         drain_done = ($urandom_range(2) == 0);
         @(negedge clk);
         check_all();
      end
      finish_run();
   end

endmodule